// File: doc/BRIEF.md
# Row-Folded 3x3 Convolution Engine

This block computes one output pixel of a 3x3 spatial filter for a single pixel lane. It takes a window of nine unsigned 8-bit pixels and applies nine signed 16-bit fixed-point weights. The hardware has three multipliers, not nine. It runs on a clock three times the pixel rate and handles one window row per fast cycle. A two-bit phase counter picks the row. Each row's three products are reduced by a small adder tree, and the three row sums are accumulated. The total is rounded and clamped to an 8-bit result.

A start pulse hands a window to the engine. The window and its sync sideband are latched on that edge, so the source may move on straight away. A new window can be started every third cycle, which keeps the engine busy without gaps. Weights are loaded through a plain write port. A wide datapath would place eight of these engines side by side, one for each pixel of a beat.

Top module: `conv3_fold_engine`

## Requirements
- R1: While rst_ni is low, and until the first result, valid_o, pix_o and sync_o are all zero. All weights reset to zero.
- R2: A write with cfg_we_i high and cfg_addr_i in 0..8 stores cfg_data_i as the weight for tap k = 3*row + col. The data is a signed value with 15 fraction bits, so 0x8000 is -1.0 and 0x4000 is +0.5. Pixel k of win_i sits at bits [8k+7:8k].
- R3: A write with cfg_addr_i of 9 or more changes no weight.
- R4: The result is S = sum over k of pixel_k * weight_k. It is rounded to nearest, with ties going up, by computing floor((S + 2^14) / 2^15).
- R5: A rounded value below 0 gives 0, and a value above 255 gives 255.
- R6: valid_o is high for exactly one cycle, on the fourth rising edge after the edge that accepted start_i. pix_o holds its value until the next result.
- R7: sync_o shows the sync_i value captured with the window, and it changes at the same edge as pix_o.
- R8: win_i and sync_i are sampled only on the accepting edge. Later changes to them do not affect that result.
- R9: start_i is accepted when the engine is idle or in its last row phase, so windows can follow each other every three cycles. A start_i in the first or second row phase is ignored and produces no result.
- R10: While busy, the phase counter steps through 0, 1, 2 and never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, three times the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Weight write strobe |
| cfg_addr_i | input | 4 | Weight tap index |
| cfg_data_i | input | 16 | Weight value, signed, 15 fraction bits |
| start_i | input | 1 | Offer a new window |
| win_i | input | 72 | Nine pixels, tap k at bits [8k+7:8k] |
| sync_i | input | 2 | Sideband that travels with the window |
| pix_o | output | 8 | Rounded, clamped result |
| valid_o | output | 1 | Result strobe |
| sync_o | output | 2 | Sideband aligned to the result |

## Verification
The assertions assume that weights are not rewritten while a window is in progress, because the row multipliers read the weight bank live. The bench therefore performs every write with start_i low and no window in flight. They also assume that start_i is only honoured in the idle or last phase. The bench checks this by raising start_i in phase 0 with a different window and confirming that no extra result appears. Inputs change on the falling clock edge, so every accept edge sees stable values.

// File: rtl/conv3_pkg.sv
package conv3_pkg;
  localparam int unsigned ROWS = 3;
  localparam int unsigned COLS = 3;
  localparam int unsigned TAPS = ROWS * COLS;

  typedef enum logic [1:0] {
    PH_ROW0 = 2'd0,
    PH_ROW1 = 2'd1,
    PH_ROW2 = 2'd2
  } phase_e;
endpackage

// File: rtl/conv3_coef_bank.sv
module conv3_coef_bank
  import conv3_pkg::*;
#(
  parameter int unsigned COEF_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [COEF_W-1:0]        data_i,
  input  logic [1:0]               row_i,
  output logic signed [COEF_W-1:0] coef_row_o [COLS]
);
  localparam int unsigned BANK_W = TAPS * COEF_W;

  logic [BANK_W-1:0] bank_q;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bank_q[k*COEF_W +: COEF_W] <= '0;
      else if (we_i && addr_i == ADDR_W'(k)) bank_q[k*COEF_W +: COEF_W] <= data_i;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    always_comb begin
      unique case (row_i)
        2'd1:    coef_row_o[c] = $signed(bank_q[(COLS + c)*COEF_W +: COEF_W]);
        2'd2:    coef_row_o[c] = $signed(bank_q[(2*COLS + c)*COEF_W +: COEF_W]);
        default: coef_row_o[c] = $signed(bank_q[c*COEF_W +: COEF_W]);
      endcase
    end
  end

  // R3: out-of-range tap index never disturbs the bank
  p_bad_addr_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i >= ADDR_W'(TAPS)) |=> $stable(bank_q));
endmodule

// File: rtl/conv3_phase_seq.sv
module conv3_phase_seq
  import conv3_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic       accept_o,
  output logic       busy_o,
  output logic       first_o,
  output logic       last_o,
  output logic [1:0] row_o
);
  logic   busy_q;
  phase_e phase_q;

  assign accept_o = start_i && (!busy_q || phase_q == PH_ROW2);
  assign busy_o   = busy_q;
  assign first_o  = busy_q && phase_q == PH_ROW0;
  assign last_o   = busy_q && phase_q == PH_ROW2;
  assign row_o    = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= PH_ROW0;
    end else if (accept_o) begin
      busy_q  <= 1'b1;
      phase_q <= PH_ROW0;
    end else if (busy_q) begin
      unique case (phase_q)
        PH_ROW0: phase_q <= PH_ROW1;
        PH_ROW1: phase_q <= PH_ROW2;
        default: begin
          phase_q <= PH_ROW0;
          busy_q  <= 1'b0;
        end
      endcase
    end
  end

  p_phase_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> phase_q != 2'd3);

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_q && phase_q != PH_ROW2) |=>
      (busy_q && phase_q == $past(phase_q) + 2'd1));
endmodule

// File: rtl/conv3_row_mac.sv
module conv3_row_mac
  import conv3_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned COEF_W = 16,
  localparam int unsigned PROD_W = PIX_W + 1 + COEF_W,
  localparam int unsigned ROW_W  = PROD_W + 2
) (
  input  logic [PIX_W-1:0]         pix_i  [COLS],
  input  logic signed [COEF_W-1:0] coef_i [COLS],
  output logic signed [ROW_W-1:0]  sum_o
);
  logic signed [PROD_W-1:0] prod [COLS];
  logic signed [ROW_W-1:0]  ext  [COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_mul
    logic signed [PIX_W:0] pix_s;
    assign pix_s   = $signed({1'b0, pix_i[c]});
    assign prod[c] = pix_s * coef_i[c];
    assign ext[c]  = {{2{prod[c][PROD_W-1]}}, prod[c]};
  end

  // two-level adder tree
  logic signed [ROW_W-1:0] pair;
  assign pair  = ext[0] + ext[1];
  assign sum_o = pair + ext[2];
endmodule

// File: rtl/conv3_fold_engine.sv
module conv3_fold_engine
  import conv3_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned FRAC_W = 15,
  parameter int unsigned SYNC_W = 2,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [ADDR_W-1:0]       cfg_addr_i,
  input  logic [COEF_W-1:0]       cfg_data_i,
  input  logic                    start_i,
  input  logic [TAPS*PIX_W-1:0]   win_i,
  input  logic [SYNC_W-1:0]       sync_i,
  output logic [PIX_W-1:0]        pix_o,
  output logic                    valid_o,
  output logic [SYNC_W-1:0]       sync_o
);
  localparam int unsigned PROD_W = PIX_W + 1 + COEF_W;
  localparam int unsigned ROW_W  = PROD_W + 2;
  localparam int unsigned ACC_W  = ROW_W + 2;
  localparam int unsigned WIN_W  = TAPS * PIX_W;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] PMAX = ACC_W'((1 << PIX_W) - 1);

  logic       accept, busy, first, last;
  logic [1:0] row_sel;

  conv3_phase_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy),
    .first_o  (first),
    .last_o   (last),
    .row_o    (row_sel)
  );

  logic signed [COEF_W-1:0] coef_row [COLS];

  conv3_coef_bank #(.COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .data_i     (cfg_data_i),
    .row_i      (row_sel),
    .coef_row_o (coef_row)
  );

  // window and sideband holding registers
  logic [WIN_W-1:0]  hold_q;
  logic [SYNC_W-1:0] sync_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      sync_hold_q <= '0;
    end else if (accept) begin
      hold_q      <= win_i;
      sync_hold_q <= sync_i;
    end
  end

  logic [PIX_W-1:0] row_pix [COLS];
  for (genvar c = 0; c < COLS; c++) begin : g_sel
    always_comb begin
      unique case (row_sel)
        2'd1:    row_pix[c] = hold_q[(COLS + c)*PIX_W +: PIX_W];
        2'd2:    row_pix[c] = hold_q[(2*COLS + c)*PIX_W +: PIX_W];
        default: row_pix[c] = hold_q[c*PIX_W +: PIX_W];
      endcase
    end
  end

  logic signed [ROW_W-1:0] row_sum;

  conv3_row_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_mac (
    .pix_i  (row_pix),
    .coef_i (coef_row),
    .sum_o  (row_sum)
  );

  // row accumulation, rounding and clamping
  logic signed [ACC_W-1:0] acc_q, row_ext, acc_sum, rounded, shifted;
  logic [PIX_W-1:0]        pix_next;

  assign row_ext = {{2{row_sum[ROW_W-1]}}, row_sum};
  assign acc_sum = (first ? '0 : acc_q) + row_ext;
  assign rounded = acc_sum + HALF;
  assign shifted = rounded >>> FRAC_W;

  always_comb begin
    if (shifted[ACC_W-1])  pix_next = '0;
    else if (shifted > PMAX) pix_next = '1;
    else                   pix_next = shifted[PIX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      pix_o   <= '0;
      valid_o <= 1'b0;
      sync_o  <= '0;
    end else begin
      if (busy) acc_q <= acc_sum;
      valid_o <= last;
      if (last) begin
        pix_o  <= pix_next;
        sync_o <= sync_hold_q;
      end
    end
  end

  p_valid_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(accept, 4));

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_sync_align_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sync_o == $past(sync_i, 4));

  p_window_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !accept) |=> $stable(hold_q));
endmodule

// File: tb/conv3_fold_engine_bench.sv
module conv3_fold_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_data = '0;
  logic        start = 1'b0;
  logic [71:0] win = '0;
  logic [1:0]  sync = '0;
  logic [7:0]  pix;
  logic        valid;
  logic [1:0]  sync_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  conv3_fold_engine u_conv3_fold_engine (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_we_i   (cfg_we),
    .cfg_addr_i (cfg_addr),
    .cfg_data_i (cfg_data),
    .start_i    (start),
    .win_i      (win),
    .sync_i     (sync),
    .pix_o      (pix),
    .valid_o    (valid),
    .sync_o     (sync_out)
  );

  // {window, sync, expected}; all weights 0x1000 (1/8)
  localparam logic [81:0] VEC [7] = '{
    {72'h080808080808080808, 2'd1, 8'd9},
    {72'h000000000000000000, 2'd2, 8'd0},
    {72'hFFFFFFFFFFFFFFFFFF, 2'd3, 8'd255},
    {72'h090807060504030201, 2'd0, 8'd6},
    {72'h00000000000000000C, 2'd1, 8'd2},
    {72'h040000000000000000, 2'd2, 8'd1},
    {72'h000000000300000000, 2'd3, 8'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_all(input logic [15:0] d);
    for (int k = 0; k < 9; k++) wr(4'(k), d);
  endtask

  // accept, scramble inputs (R8), sample after the fourth edge
  task automatic run(input string req, input logic [71:0] w, input logic [1:0] s,
                     input logic [7:0] exp);
    @(negedge clk);
    start = 1'b1; win = w; sync = s;
    @(negedge clk);
    start = 1'b0; win = ~w; sync = ~s;
    @(negedge clk);
    @(negedge clk);
    chk({req, " valid before latency (R6)"}, 32'(valid), 0);
    @(negedge clk);
    chk({req, " valid (R6)"}, 32'(valid), 1);
    chk(req, 32'(pix), 32'(exp));
    chk({req, " sync (R7)"}, 32'(sync_out), 32'(s));
    @(negedge clk);
    chk({req, " single pulse (R6)"}, 32'(valid), 0);
    chk({req, " pix held (R6)"}, 32'(pix), 32'(exp));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(valid), 0);
    chk("R1 pix in reset", 32'(pix), 0);
    chk("R1 sync in reset", 32'(sync_out), 0);
    rst_n = 1'b1;
    run("R1 zero weights", 72'hFFFFFFFFFFFFFFFFFF, 2'd1, 8'd0);

    set_all(16'h1000);
    for (int i = 0; i < 7; i++)
      run("R4/R5/R8 table", VEC[i][81:10], VEC[i][9:8], VEC[i][7:0]);

    // R9: back-to-back, with a start in phase 0 that must be ignored
    @(negedge clk); start = 1'b1; win = {9{8'd8}};  sync = 2'd1;
    @(negedge clk); start = 1'b1; win = {9{8'd16}}; sync = 2'd3;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1; win = {9{8'd24}}; sync = 2'd2;
    @(negedge clk); start = 1'b0; win = '0; sync = '0;
    chk("R9 first valid", 32'(valid), 1);
    chk("R9 first pix", 32'(pix), 9);
    chk("R9 first sync", 32'(sync_out), 1);
    @(negedge clk); chk("R9 gap", 32'(valid), 0);
    @(negedge clk); chk("R9 gap", 32'(valid), 0);
    @(negedge clk);
    chk("R9 second valid", 32'(valid), 1);
    chk("R9 second pix", 32'(pix), 27);
    chk("R9 second sync", 32'(sync_out), 2);
    repeat (4) begin
      @(negedge clk); chk("R9 ignored start made no result", 32'(valid), 0);
    end

    // R2: tap 5 (row 1, col 2) only
    set_all(16'h0000);
    wr(4'd5, 16'h4000);
    run("R2 tap5 hit", {8'd0, 8'd0, 8'd0, 8'd200, 40'h0}, 2'd0, 8'd100);
    run("R2 tap7 miss", {8'd0, 8'd200, 56'h0}, 2'd0, 8'd0);

    // R3: out-of-range writes leave weights at zero except tap 5
    wr(4'd9, 16'h7FFF);
    wr(4'd12, 16'h7FFF);
    wr(4'd15, 16'h7FFF);
    run("R3 bad address ignored", {9{8'd100}}, 2'd1, 8'd50);

    // R4 mixed signs and rounding ties
    set_all(16'h0000);
    wr(4'd0, 16'h4000);
    wr(4'd1, 16'hC000);
    run("R4 signed 1.0", {56'h0, 8'd1, 8'd3}, 2'd2, 8'd1);
    run("R4 tie to zero", {56'h0, 8'd1, 8'd0}, 2'd2, 8'd0);
    wr(4'd1, 16'h0000);
    wr(4'd0, 16'h7FFF);
    run("R4 near-unity weight", {64'h0, 8'd200}, 2'd3, 8'd200);

    // R5 negative clamp
    set_all(16'h0000);
    wr(4'd4, 16'h8000);
    run("R5 negative clamp", {9{8'd50}}, 2'd0, 8'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule